// File: doc/BRIEF.md
# Accumulator Subtract and Flag Unit

This block is one slice of an accumulator datapath. Each cycle it takes an operation code with its operands, updates a 32-bit accumulator, and keeps two flags: a carry flag `c_flag` and a test flag `tc_flag`. The operations are plain subtraction, subtraction of a zero-extended halfword, and subtraction with borrow. Two conditional-subtract division steps are included; each performs one restoring-division iteration. There is also a bit test, a normalize-style flag evaluation, an add of the product register, and an accumulator load. The carry flag always means "no borrow" for subtractions and "carry out" for the add.

The operation is applied on the clock edge that ends the cycle. Dedicated strobes can force either flag to 1 or to 0. A strobe overrides any flag value that the operation in the same cycle would produce. Instruction decode, addressing, overflow handling and branching stay outside the block.

Top module: `acc_sub_flag_unit`

## Requirements
- R1: After reset, `acc` is 0, `c_flag` is 0 and `tc_flag` is 0.
- R2: Code 2 (full subtract) writes `acc - mem_opnd`. Code 3 (halfword subtract) writes `acc - zext(mem_opnd[15:0])`. In both cases `c_flag` becomes 1 when the subtraction does not borrow (unsigned minuend >= subtrahend) and 0 when it does.
- R3: Code 4 (subtract with borrow) writes `acc - (mem_opnd + (1 - c_flag))`. `c_flag` becomes 1 exactly when that subtraction does not borrow.
- R4: Code 5 (halfword division step) forms `d = acc - (zext(mem_opnd[15:0]) << 15)`. With no borrow, `acc` becomes `(d << 1) | 1` and `c_flag` becomes 1. With a borrow, `acc` becomes `acc << 1` and `c_flag` becomes 0. Sixteen steps on a 16-bit dividend leave the quotient in `acc[15:0]` and the remainder in `acc[31:16]`.
- R5: Code 6 (word division step) forms `s = (acc << 1) | p_val[31]`, truncated to 32 bits. With no borrow, `acc` becomes `s - mem_opnd` and `c_flag` becomes 1. With a borrow, `acc` becomes `s` and `c_flag` becomes 0.
- R6: Code 7 (bit test) loads `tc_flag` with `mem_opnd[bit_sel]`.
- R7: Code 8 (normalize test) sets `tc_flag` to 1 when `acc` is zero. Otherwise it loads `tc_flag` with `acc[31] ^ acc[30]`.
- R8: Code 9 (product add) writes `acc + p_val`. `c_flag` becomes the carry out of bit 31.
- R9: Code 1 (load) writes `mem_opnd` into `acc` and leaves both flags unchanged.
- R10: When `tc_set` is high, `tc_flag` becomes 1 on the next edge. When only `tc_clr` is high, `tc_flag` becomes 0. Either strobe overrides the operation's TC result.
- R11: When `c_set` is high, `c_flag` becomes 1 on the next edge. When only `c_clr` is high, `c_flag` becomes 0. Either strobe overrides the operation's C result.
- R12: Codes 1 to 6 and 9 leave `tc_flag` unchanged. Codes 7 and 8 leave `acc` and `c_flag` unchanged. Code 0 and all codes above 9 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation selector (codes as in the requirements) |
| mem_opnd | input | 32 | Memory operand; the halfword operations use bits 15:0 |
| p_val | input | 32 | Product register value |
| bit_sel | input | 5 | Bit index for the bit test |
| c_set | input | 1 | Force carry flag to 1 |
| c_clr | input | 1 | Force carry flag to 0 |
| tc_set | input | 1 | Force test flag to 1 |
| tc_clr | input | 1 | Force test flag to 0 |
| acc | output | 32 | Accumulator |
| c_flag | output | 1 | Carry / no-borrow flag |
| tc_flag | output | 1 | Test/control flag |

## Verification
Every result is held in a single register stage. The accumulator and both flags therefore show the effect of an operation one rising edge after the cycle in which it was presented. The bench drives each operation on a falling edge and returns the code to 0 on the next falling edge. It reads `acc`, `c_flag` and `tc_flag` at that same falling edge, half a period after the updating edge. Because the idle code follows, an output that changed too late or spuriously shows up in the next sample. The sixteen-step division runs back to back with one operation per cycle and is checked after the last step.

// File: rtl/acc_sub_pkg.sv
package acc_sub_pkg;

   typedef enum logic [3:0] {
      OP_IDLE   = 4'd0,
      OP_LOAD   = 4'd1,
      OP_SUBW   = 4'd2,
      OP_SUBH   = 4'd3,
      OP_SUBBRW = 4'd4,
      OP_DSTEPH = 4'd5,
      OP_DSTEPW = 4'd6,
      OP_BTEST  = 4'd7,
      OP_NTEST  = 4'd8,
      OP_ADDPR  = 4'd9
   } acc_op_e;

   typedef struct packed {
      logic acc_we;
      logic c_we;
      logic tc_we;
   } upd_en_s;

endpackage

// File: rtl/acc_sub_arith.sv
module acc_sub_arith
   import acc_sub_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int HALF_W = 16
) (
   input  acc_op_e          op,
   input  logic [ACC_W-1:0] acc_cur,
   input  logic [ACC_W-1:0] opnd,
   input  logic [ACC_W-1:0] prod,
   input  logic             c_cur,
   output logic [ACC_W-1:0] acc_nxt,
   output logic             acc_we,
   output logic             c_nxt,
   output logic             c_we
);

   localparam int DSH = HALF_W - 1;
   localparam int SW  = ACC_W + 1;

   initial begin
      if (ACC_W < 4)       $error("acc_sub_arith: ACC_W too small");
      if (HALF_W < 2)      $error("acc_sub_arith: HALF_W too small");
      if (HALF_W > ACC_W)  $error("acc_sub_arith: HALF_W exceeds ACC_W");
   end

   logic [ACC_W-1:0] half_ext;

   generate
      if (HALF_W < ACC_W) begin : g_zext
         assign half_ext = {{(ACC_W-HALF_W){1'b0}}, opnd[HALF_W-1:0]};
      end else begin : g_full
         assign half_ext = opnd;
      end
   endgenerate

   logic [ACC_W-1:0] sub_a;
   logic [ACC_W-1:0] sub_b;
   logic             sub_cin;
   logic [SW-1:0]    sub_sum;
   logic [SW-1:0]    add_sum;
   logic             no_borrow;

   always_comb begin
      sub_a   = acc_cur;
      sub_b   = opnd;
      sub_cin = 1'b1;
      unique case (op)
         OP_SUBH:   sub_b   = half_ext;
         OP_SUBBRW: sub_cin = c_cur;
         OP_DSTEPH: sub_b   = half_ext << DSH;
         OP_DSTEPW: sub_a   = {acc_cur[ACC_W-2:0], prod[ACC_W-1]};
         default:   ;
      endcase
   end

   assign sub_sum   = {1'b0, sub_a} + {1'b0, ~sub_b} + SW'(sub_cin);
   assign no_borrow = sub_sum[ACC_W];
   assign add_sum   = {1'b0, acc_cur} + {1'b0, prod};

   always_comb begin
      acc_nxt = acc_cur;
      acc_we  = 1'b0;
      c_nxt   = c_cur;
      c_we    = 1'b0;
      case (op)
         OP_LOAD: begin
            acc_nxt = opnd;
            acc_we  = 1'b1;
         end
         OP_SUBW, OP_SUBH, OP_SUBBRW: begin
            acc_nxt = sub_sum[ACC_W-1:0];
            acc_we  = 1'b1;
            c_nxt   = no_borrow;
            c_we    = 1'b1;
         end
         OP_DSTEPH: begin
            acc_nxt = no_borrow ? {sub_sum[ACC_W-2:0], 1'b1}
                                : {acc_cur[ACC_W-2:0], 1'b0};
            acc_we  = 1'b1;
            c_nxt   = no_borrow;
            c_we    = 1'b1;
         end
         OP_DSTEPW: begin
            acc_nxt = no_borrow ? sub_sum[ACC_W-1:0] : sub_a;
            acc_we  = 1'b1;
            c_nxt   = no_borrow;
            c_we    = 1'b1;
         end
         OP_ADDPR: begin
            acc_nxt = add_sum[ACC_W-1:0];
            acc_we  = 1'b1;
            c_nxt   = add_sum[ACC_W];
            c_we    = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_tc_eval.sv
module acc_tc_eval
   import acc_sub_pkg::*;
#(
   parameter int ACC_W = 32,
   localparam int IDX_W = $clog2(ACC_W)
) (
   input  acc_op_e          op,
   input  logic [ACC_W-1:0] acc_cur,
   input  logic [ACC_W-1:0] opnd,
   input  logic [IDX_W-1:0] bit_sel,
   output logic             tc_nxt,
   output logic             tc_we
);

   initial begin
      if (ACC_W < 4) $error("acc_tc_eval: ACC_W too small");
   end

   logic bit_val;
   logic acc_zero;
   logic sign_redund;

   generate
      if ((1 << IDX_W) == ACC_W) begin : g_pow2
         assign bit_val = opnd[bit_sel];
      end else begin : g_range
         assign bit_val = (int'(bit_sel) < ACC_W) ? opnd[bit_sel] : 1'b0;
      end
   endgenerate

   assign acc_zero    = (acc_cur == '0);
   assign sign_redund = acc_cur[ACC_W-1] ^ acc_cur[ACC_W-2];

   always_comb begin
      tc_nxt = 1'b0;
      tc_we  = 1'b0;
      case (op)
         OP_BTEST: begin
            tc_nxt = bit_val;
            tc_we  = 1'b1;
         end
         OP_NTEST: begin
            tc_nxt = acc_zero | sign_redund;
            tc_we  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_flag_bit.sv
module acc_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic force_one,
   input  logic force_zero,
   input  logic upd_we,
   input  logic upd_val,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (force_one)  q <= 1'b1;
      else if (force_zero) q <= 1'b0;
      else if (upd_we)     q <= upd_val;
   end

   // R10 R11
   flag_force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_one |=> q);

   // R10 R11
   flag_force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_zero && !force_one) |=> !q);

   // R12
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_one && !force_zero && !upd_we) |=> $stable(q));

endmodule

// File: rtl/acc_sub_flag_unit.sv
module acc_sub_flag_unit
   import acc_sub_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int HALF_W = 16,
   localparam int IDX_W = $clog2(ACC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_code,
   input  logic [ACC_W-1:0] mem_opnd,
   input  logic [ACC_W-1:0] p_val,
   input  logic [IDX_W-1:0] bit_sel,
   input  logic             c_set,
   input  logic             c_clr,
   input  logic             tc_set,
   input  logic             tc_clr,
   output logic [ACC_W-1:0] acc,
   output logic             c_flag,
   output logic             tc_flag
);

   acc_op_e          op;
   upd_en_s          upd;
   logic [ACC_W-1:0] acc_nxt;
   logic             c_nxt;
   logic             tc_nxt;

   assign op = acc_op_e'(op_code);

   acc_sub_arith #(.ACC_W(ACC_W), .HALF_W(HALF_W)) arith_i (
      .op      (op),
      .acc_cur (acc),
      .opnd    (mem_opnd),
      .prod    (p_val),
      .c_cur   (c_flag),
      .acc_nxt (acc_nxt),
      .acc_we  (upd.acc_we),
      .c_nxt   (c_nxt),
      .c_we    (upd.c_we)
   );

   acc_tc_eval #(.ACC_W(ACC_W)) tc_eval_i (
      .op      (op),
      .acc_cur (acc),
      .opnd    (mem_opnd),
      .bit_sel (bit_sel),
      .tc_nxt  (tc_nxt),
      .tc_we   (upd.tc_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc <= '0;
      else if (upd.acc_we) acc <= acc_nxt;
   end

   acc_flag_bit c_bit_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_one  (c_set),
      .force_zero (c_clr),
      .upd_we     (upd.c_we),
      .upd_val    (c_nxt),
      .q          (c_flag)
   );

   acc_flag_bit tc_bit_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_one  (tc_set),
      .force_zero (tc_clr),
      .upd_we     (upd.tc_we),
      .upd_val    (tc_nxt),
      .q          (tc_flag)
   );

   // R12
   acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd0 || op_code > 4'd9) |=> $stable(acc));

   // R12
   acc_test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd7 || op_code == 4'd8) |=> $stable(acc));

   // R7
   norm_zero_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd8 && acc == '0 && !tc_clr) |=> tc_flag);

   // R9
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd1) |=> (acc == $past(mem_opnd)));

endmodule

// File: tb/acc_sub_flag_unit_tb.sv
module acc_sub_flag_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic [31:0] mem_opnd = '0;
   logic [31:0] p_val = '0;
   logic [4:0]  bit_sel = '0;
   logic        c_set = 1'b0, c_clr = 1'b0, tc_set = 1'b0, tc_clr = 1'b0;
   logic [31:0] acc;
   logic        c_flag, tc_flag;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   acc_sub_flag_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .mem_opnd(mem_opnd),
      .p_val(p_val), .bit_sel(bit_sel), .c_set(c_set), .c_clr(c_clr),
      .tc_set(tc_set), .tc_clr(tc_clr), .acc(acc), .c_flag(c_flag),
      .tc_flag(tc_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   // Present one operation for one cycle, then return to idle; results are
   // valid at the falling edge that ends this task.
   task automatic run_op(input logic [3:0] op, input logic [31:0] m,
                         input logic [31:0] p, input logic [4:0] b,
                         input logic cs, input logic cc,
                         input logic ts, input logic tcl);
      @(negedge clk);
      op_code = op; mem_opnd = m; p_val = p; bit_sel = b;
      c_set = cs; c_clr = cc; tc_set = ts; tc_clr = tcl;
      @(negedge clk);
      op_code = 4'd0; c_set = 0; c_clr = 0; tc_set = 0; tc_clr = 0;
   endtask

   task automatic do_op(input logic [3:0] op, input logic [31:0] m,
                        input logic [31:0] p);
      run_op(op, m, p, 5'd0, 0, 0, 0, 0);
   endtask

   task automatic set_c(input logic v);
      run_op(4'd0, 0, 0, 0, v, !v, 0, 0);
   endtask

   task automatic set_tc(input logic v);
      run_op(4'd0, 0, 0, 0, 0, 0, v, !v);
   endtask

   task automatic t_reset;
      check("R1", "acc", acc, 32'h0);
      check("R1", "c", {31'b0, c_flag}, 32'h0);
      check("R1", "tc", {31'b0, tc_flag}, 32'h0);
   endtask

   task automatic t_sub;
      set_tc(1);
      do_op(4'd1, 32'd5, 0); do_op(4'd2, 32'd3, 0);
      check("R2", "5-3 acc", acc, 32'd2);
      check("R2", "5-3 c", {31'b0, c_flag}, 32'd1);
      check("R12", "sub keeps tc", {31'b0, tc_flag}, 32'd1);
      do_op(4'd1, 32'd3, 0); do_op(4'd2, 32'd5, 0);
      check("R2", "3-5 acc", acc, 32'hFFFF_FFFE);
      check("R2", "3-5 c", {31'b0, c_flag}, 32'd0);
      do_op(4'd1, 32'd7, 0); do_op(4'd2, 32'd7, 0);
      check("R2", "7-7 acc", acc, 32'd0);
      check("R2", "7-7 c", {31'b0, c_flag}, 32'd1);
      do_op(4'd1, 32'h0001_0000, 0); do_op(4'd3, 32'hFFFF_0001, 0);
      check("R2", "half acc", acc, 32'h0000_FFFF);
      check("R2", "half c", {31'b0, c_flag}, 32'd1);
   endtask

   task automatic t_subb;
      set_c(0); do_op(4'd1, 32'd10, 0); do_op(4'd4, 32'd3, 0);
      check("R3", "c0 acc", acc, 32'd6);
      check("R3", "c0 c", {31'b0, c_flag}, 32'd1);
      do_op(4'd1, 32'd10, 0); do_op(4'd4, 32'd3, 0);
      check("R3", "c1 acc", acc, 32'd7);
      set_c(0); do_op(4'd1, 32'd0, 0); do_op(4'd4, 32'd0, 0);
      check("R3", "c0 zero acc", acc, 32'hFFFF_FFFF);
      check("R3", "c0 zero c", {31'b0, c_flag}, 32'd0);
      set_c(1); do_op(4'd1, 32'd0, 0); do_op(4'd4, 32'd0, 0);
      check("R3", "c1 zero acc", acc, 32'd0);
      check("R3", "c1 zero c", {31'b0, c_flag}, 32'd1);
   endtask

   task automatic t_dsteph;
      do_op(4'd1, 32'h0001_8000, 0); do_op(4'd5, 32'd1, 0);
      check("R4", "no borrow acc", acc, 32'h0002_0001);
      check("R4", "no borrow c", {31'b0, c_flag}, 32'd1);
      do_op(4'd1, 32'h0000_4000, 0); do_op(4'd5, 32'd1, 0);
      check("R4", "borrow acc", acc, 32'h0000_8000);
      check("R4", "borrow c", {31'b0, c_flag}, 32'd0);
      do_op(4'd1, 32'd100, 0);
      @(negedge clk);
      op_code = 4'd5; mem_opnd = 32'd7;
      for (int i = 0; i < 16; i++) @(negedge clk);
      op_code = 4'd0;
      check("R4", "100/7 rem:quo", acc, {16'd2, 16'd14});
   endtask

   task automatic t_dstepw;
      do_op(4'd1, 32'd4, 0); do_op(4'd6, 32'd5, 32'h8000_0000);
      check("R5", "no borrow acc", acc, 32'd4);
      check("R5", "no borrow c", {31'b0, c_flag}, 32'd1);
      do_op(4'd1, 32'd1, 0); do_op(4'd6, 32'd5, 32'h7FFF_FFFF);
      check("R5", "borrow acc", acc, 32'd2);
      check("R5", "borrow c", {31'b0, c_flag}, 32'd0);
   endtask

   task automatic t_btest;
      set_c(1); do_op(4'd1, 32'h1234_5678, 0);
      run_op(4'd7, 32'h8000_0000, 0, 5'd31, 0, 0, 0, 0);
      check("R6", "bit31", {31'b0, tc_flag}, 32'd1);
      check("R12", "btest keeps acc", acc, 32'h1234_5678);
      check("R12", "btest keeps c", {31'b0, c_flag}, 32'd1);
      run_op(4'd7, 32'h8000_0000, 0, 5'd30, 0, 0, 0, 0);
      check("R6", "bit30", {31'b0, tc_flag}, 32'd0);
      run_op(4'd7, 32'h0000_0001, 0, 5'd0, 0, 0, 0, 0);
      check("R6", "bit0", {31'b0, tc_flag}, 32'd1);
   endtask

   task automatic t_ntest;
      set_tc(0); do_op(4'd1, 32'd0, 0); do_op(4'd8, 0, 0);
      check("R7", "zero", {31'b0, tc_flag}, 32'd1);
      check("R12", "ntest keeps acc", acc, 32'd0);
      do_op(4'd1, 32'h4000_0000, 0); do_op(4'd8, 0, 0);
      check("R7", "01", {31'b0, tc_flag}, 32'd1);
      do_op(4'd1, 32'hC000_0000, 0); do_op(4'd8, 0, 0);
      check("R7", "11", {31'b0, tc_flag}, 32'd0);
      set_tc(1); do_op(4'd1, 32'd1, 0); do_op(4'd8, 0, 0);
      check("R7", "00 nonzero", {31'b0, tc_flag}, 32'd0);
   endtask

   task automatic t_addp;
      do_op(4'd1, 32'hFFFF_FFFF, 0); do_op(4'd9, 0, 32'd1);
      check("R8", "wrap acc", acc, 32'd0);
      check("R8", "wrap c", {31'b0, c_flag}, 32'd1);
      do_op(4'd1, 32'd1, 0); do_op(4'd9, 0, 32'd1);
      check("R8", "small acc", acc, 32'd2);
      check("R8", "small c", {31'b0, c_flag}, 32'd0);
   endtask

   task automatic t_load_idle;
      set_c(1); set_tc(1);
      do_op(4'd1, 32'hDEAD_BEEF, 0);
      check("R9", "load acc", acc, 32'hDEAD_BEEF);
      check("R9", "load c", {31'b0, c_flag}, 32'd1);
      check("R9", "load tc", {31'b0, tc_flag}, 32'd1);
      do_op(4'd12, 32'h1, 32'h1);
      check("R12", "undefined code acc", acc, 32'hDEAD_BEEF);
      check("R12", "undefined code c", {31'b0, c_flag}, 32'd1);
   endtask

   task automatic t_strobes;
      run_op(4'd7, 32'hFFFF_FFFF, 0, 5'd3, 0, 0, 0, 1);
      check("R10", "clr beats btest", {31'b0, tc_flag}, 32'd0);
      do_op(4'd1, 32'hC000_0000, 0);
      run_op(4'd8, 0, 0, 0, 0, 0, 1, 0);
      check("R10", "set beats ntest", {31'b0, tc_flag}, 32'd1);
      run_op(4'd0, 0, 0, 0, 0, 0, 1, 1);
      check("R10", "set beats clr", {31'b0, tc_flag}, 32'd1);
      do_op(4'd1, 32'd5, 0);
      run_op(4'd2, 32'd3, 0, 0, 0, 1, 0, 0);
      check("R11", "clr beats sub", {31'b0, c_flag}, 32'd0);
      check("R11", "sub acc still written", acc, 32'd2);
      run_op(4'd2, 32'd9, 0, 0, 1, 0, 0, 0);
      check("R11", "set beats borrow", {31'b0, c_flag}, 32'd1);
      run_op(4'd0, 0, 0, 0, 1, 1, 0, 0);
      check("R11", "set beats clr", {31'b0, c_flag}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sub();
      t_subb();
      t_dsteph();
      t_dstepw();
      t_btest();
      t_ntest();
      t_addp();
      t_load_idle();
      t_strobes();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule